// File: doc/BRIEF.md
# Two-Tier Preemptive Thread Scheduler

This block decides which hardware thread a small coprocessor core executes. Each request channel carries a configured priority level. Levels 1 to 3 form a low tier and levels 4 to 7 form a high tier. Level 0 disables the channel. Request pulses are latched as pending. Whenever the core is free, the scheduler dispatches the pending channel with the highest level. It reports the running channel and whether a thread is active.

A running low-tier thread is preempted when a high-tier request becomes pending. The scheduler then pulses a preempt strobe and drives a save strobe for a fixed number of cycles, while the core copies its registers into a single shadow bank. Only after that does the high-tier thread start. High-tier threads always run to completion, so nesting never goes deeper than one level. When the high-tier work is done, a restore strobe runs for a fixed number of cycles and the preempted thread resumes. When a running thread signals completion, a one-cycle interrupt pulse is raised on that channel's own output bit towards the host.

Top module: `thread_sched`

## Requirements
- R1: A channel whose level is 0 is never dispatched, and a request on such a channel is ignored.
- R2: When dispatching from idle, the pending channel with the highest level wins. On equal levels, the lowest channel number wins.
- R3: A pending low-tier request (level 1 to 3) never interrupts a running thread. It waits until that thread completes.
- R4: A running low-tier thread with a high-tier request pending is preempted. `preempt_o` pulses for one cycle, which is the first cycle of `save_o`. `save_o` stays high for exactly SAVE_CYC cycles. In the cycle after that, the highest pending high-tier channel runs.
- R5: A running high-tier thread (level 4 to 7) is never preempted, whatever becomes pending.
- R6: When the core goes idle with a context held, any pending high-tier request is dispatched first. Otherwise `restore_o` is high for exactly RESTORE_CYC cycles, and the preempted channel then resumes ahead of all other pending low-tier requests.
- R7: `busy_o` is low in every cycle in which `save_o` or `restore_o` is high.
- R8: `done_i` sampled while `busy_o` is high ends the thread. In the next cycle, `irq_o` carries a single one-cycle pulse on the bit equal to the finished channel number, and `busy_o` is low. `done_i` while `busy_o` is low has no effect.
- R9: A request pulse is latched at a clock edge. If the core is idle, the thread starts at the following edge. The latch holds until the channel is dispatched.
- R10: During and right after reset, `busy_o`, `preempt_o`, `save_o`, `restore_o` and `irq_o` are all low, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_CH | Per-channel request pulses |
| lvl_i | input | N_CH*LVL_W | Per-channel priority levels; channel c at bits [c*LVL_W +: LVL_W] |
| done_i | input | 1 | Running thread has finished |
| busy_o | output | 1 | A thread is running |
| act_ch_o | output | CH_W | Channel of the running thread |
| preempt_o | output | 1 | One-cycle strobe when a preemption starts |
| save_o | output | 1 | Context save in progress |
| restore_o | output | 1 | Context restore in progress |
| irq_o | output | N_CH | Per-channel completion interrupt pulses |

## Verification
The bench builds the block with eight channels, three-bit levels, a high tier starting at level 4, and two-cycle save and restore. This means every level from 0 to 7 can be assigned. Equal levels on different channels can be set up for tie breaking. Several high-tier requests can queue up while a context is held. Randomly reassigned levels, together with random requests and completions, drive chains of preemption and resumption. A cycle-level reference model follows every strobe and channel number across these chains.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN_LO  = 3'd1,
    ST_RUN_HI  = 3'd2,
    ST_SAVE    = 3'd3,
    ST_RESTORE = 3'd4
  } sched_state_e;

endpackage

// File: rtl/ts_pending.sv
module ts_pending #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CH-1:0]         req_i,
  input  logic [N_CH*LVL_W-1:0]   lvl_i,
  input  logic [N_CH-1:0]         clr_i,
  output logic [N_CH-1:0]         pend_o
);

  logic [N_CH-1:0] enabled;
  logic [N_CH-1:0] pend_q;
  logic [N_CH-1:0] pend_d;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign enabled[g] = |lvl_i[g*LVL_W +: LVL_W];
  end

  // a new request wins over a same-cycle clear so it is not lost
  assign pend_d = (pend_q & ~clr_i) | (req_i & enabled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/ts_arbiter.sv
module ts_arbiter #(
  parameter int N_CH  = 8,
  parameter int LVL_W = 3,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]       pend_i,
  input  logic [N_CH*LVL_W-1:0] lvl_i,
  output logic                  vld_o,
  output logic [CH_W-1:0]       ch_o,
  output logic [LVL_W-1:0]      lvl_o
);

  logic [LVL_W-1:0] best_lvl;
  logic [CH_W-1:0]  best_ch;

  // strict greater-than keeps the lowest index on a tie; level 0 never beats 0
  always_comb begin
    best_lvl = '0;
    best_ch  = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (pend_i[i] && (lvl_i[i*LVL_W +: LVL_W] > best_lvl)) begin
        best_lvl = lvl_i[i*LVL_W +: LVL_W];
        best_ch  = CH_W'(i);
      end
    end
  end

  assign vld_o = |best_lvl;
  assign ch_o  = best_ch;
  assign lvl_o = best_lvl;

endmodule

// File: rtl/ts_ctx_seq.sv
module ts_ctx_seq #(
  parameter int SAVE_CYC    = 2,
  parameter int RESTORE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic save_i,
  input  logic restore_i,
  output logic first_o,
  output logic last_o
);

  localparam int MAXC  = (SAVE_CYC > RESTORE_CYC) ? SAVE_CYC : RESTORE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SAVE_LAST    = CNT_W'(SAVE_CYC - 1);
  localparam logic [CNT_W-1:0] RESTORE_LAST = CNT_W'(RESTORE_CYC - 1);

  logic             active;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign active = save_i | restore_i;
  assign cnt_en = active | (|cnt_q);
  assign cnt_d  = active ? (cnt_q + CNT_W'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign first_o = active && (cnt_q == '0);
  assign last_o  = (save_i && (cnt_q == SAVE_LAST)) ||
                   (restore_i && (cnt_q == RESTORE_LAST));

endmodule

// File: rtl/thread_sched.sv
module thread_sched
  import thread_sched_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int LVL_W       = 3,
  parameter int HI_MIN      = 4,
  parameter int SAVE_CYC    = 2,
  parameter int RESTORE_CYC = 2,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       req_i,
  input  logic [N_CH*LVL_W-1:0] lvl_i,
  input  logic                  done_i,
  output logic                  busy_o,
  output logic [CH_W-1:0]       act_ch_o,
  output logic                  preempt_o,
  output logic                  save_o,
  output logic                  restore_o,
  output logic [N_CH-1:0]       irq_o
);

  localparam logic [LVL_W-1:0] HI_LVL = LVL_W'(HI_MIN);

  sched_state_e     state_q, state_d;
  logic [CH_W-1:0]  act_q, act_d;
  logic             act_we;
  logic [CH_W-1:0]  saved_q, saved_d;
  logic             held_q, held_d;
  logic [N_CH-1:0]  irq_q, irq_d;
  logic [N_CH-1:0]  clr;
  logic [N_CH-1:0]  pend;
  logic             win_vld;
  logic [CH_W-1:0]  win_ch;
  logic [LVL_W-1:0] win_lvl;
  logic             win_hi;
  logic             in_save, in_restore;
  logic             ctx_first, ctx_last;

  ts_pending #(.N_CH(N_CH), .LVL_W(LVL_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .lvl_i  (lvl_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  ts_arbiter #(.N_CH(N_CH), .LVL_W(LVL_W)) u_arb (
    .pend_i (pend),
    .lvl_i  (lvl_i),
    .vld_o  (win_vld),
    .ch_o   (win_ch),
    .lvl_o  (win_lvl)
  );

  assign in_save    = (state_q == ST_SAVE);
  assign in_restore = (state_q == ST_RESTORE);

  ts_ctx_seq #(.SAVE_CYC(SAVE_CYC), .RESTORE_CYC(RESTORE_CYC)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .save_i    (in_save),
    .restore_i (in_restore),
    .first_o   (ctx_first),
    .last_o    (ctx_last)
  );

  assign win_hi = win_vld && (win_lvl >= HI_LVL);

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    act_we  = 1'b0;
    saved_d = saved_q;
    held_d  = held_q;
    irq_d   = '0;
    clr     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (held_q && !win_hi) begin
          state_d = ST_RESTORE;
        end else if (win_vld) begin
          state_d     = win_hi ? ST_RUN_HI : ST_RUN_LO;
          act_d       = win_ch;
          act_we      = 1'b1;
          clr[win_ch] = 1'b1;
        end
      end
      ST_RUN_LO: begin
        if (done_i) begin
          irq_d[act_q] = 1'b1;
          state_d      = ST_IDLE;
        end else if (win_hi) begin
          state_d = ST_SAVE;
          saved_d = act_q;
          held_d  = 1'b1;
        end
      end
      ST_RUN_HI: begin
        if (done_i) begin
          irq_d[act_q] = 1'b1;
          state_d      = ST_IDLE;
        end
      end
      ST_SAVE: begin
        if (ctx_last) begin
          if (win_hi) begin
            state_d     = ST_RUN_HI;
            act_d       = win_ch;
            act_we      = 1'b1;
            clr[win_ch] = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RESTORE: begin
        if (ctx_last) begin
          state_d = ST_RUN_LO;
          act_d   = saved_q;
          act_we  = 1'b1;
          held_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      saved_q <= '0;
      held_q  <= 1'b0;
      irq_q   <= '0;
    end else begin
      state_q <= state_d;
      saved_q <= saved_d;
      held_q  <= held_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_we) act_q <= act_d;
  end

  assign busy_o    = (state_q == ST_RUN_LO) || (state_q == ST_RUN_HI);
  assign act_ch_o  = act_q;
  assign preempt_o = in_save && ctx_first;
  assign save_o    = in_save;
  assign restore_o = in_restore;
  assign irq_o     = irq_q;

endmodule

// File: rtl/thread_sched_chk.sv
module thread_sched_chk
  import thread_sched_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int SAVE_CYC    = 2,
  parameter int RESTORE_CYC = 2,
  parameter int CH_W        = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done_i,
  input logic            busy_o,
  input logic [CH_W-1:0] act_ch_o,
  input logic            preempt_o,
  input logic            save_o,
  input logic            restore_o,
  input logic [N_CH-1:0] irq_o,
  input sched_state_e    state_q
);

  int unsigned     save_run;
  int unsigned     rest_run;
  logic [CH_W-1:0] victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_run <= 0;
      rest_run <= 0;
      victim   <= '0;
    end else begin
      save_run <= save_o ? save_run + 1 : 0;
      rest_run <= restore_o ? rest_run + 1 : 0;
      if (preempt_o) victim <= act_ch_o;
    end
  end

  a_r7_idle_in_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o || restore_o) |-> !busy_o);

  a_r4_preempt_opens_save: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> (save_o && !$past(save_o)));

  a_r4_save_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(save_o) |-> (save_run == SAVE_CYC));

  a_r6_restore_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restore_o) |-> (rest_run == RESTORE_CYC));

  a_r6_resume_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restore_o) |-> (busy_o && act_ch_o == victim));

  a_r5_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN_HI) |=> !save_o);

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> ($past(busy_o && done_i) &&
                  irq_o == (N_CH'(1) << $past(act_ch_o)) && !busy_o));

endmodule

bind thread_sched thread_sched_chk #(
  .N_CH(N_CH), .SAVE_CYC(SAVE_CYC), .RESTORE_CYC(RESTORE_CYC), .CH_W(CH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done_i    (done_i),
  .busy_o    (busy_o),
  .act_ch_o  (act_ch_o),
  .preempt_o (preempt_o),
  .save_o    (save_o),
  .restore_o (restore_o),
  .irq_o     (irq_o),
  .state_q   (state_q)
);

// File: tb/thread_sched_test.sv
`timescale 1ns/1ps
module thread_sched_test;

  localparam int N = 8;
  localparam int LW = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          done;
  logic [LW-1:0] lvl [N];
  logic [N*LW-1:0] lvl_flat;
  logic          busy, preempt, save, restore;
  logic [CW-1:0] act;
  logic [N-1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) lvl_flat[i*LW +: LW] = lvl[i];

  thread_sched #(.N_CH(N), .LVL_W(LW), .HI_MIN(4), .SAVE_CYC(2), .RESTORE_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_i(lvl_flat), .done_i(done),
    .busy_o(busy), .act_ch_o(act), .preempt_o(preempt), .save_o(save),
    .restore_o(restore), .irq_o(irq)
  );

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  // reference model: 0 idle, 1 run low, 2 run high, 3 save, 4 restore
  int m_st, m_cnt, m_act, m_saved;
  bit m_held;
  logic [N-1:0] m_pend, m_irq;

  function automatic int pick();
    int w = -1;
    int bl = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && int'(lvl[i]) > bl) begin bl = int'(lvl[i]); w = i; end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_act = 0; m_saved = 0; m_held = 0;
      m_pend = '0; m_irq = '0;
    end else begin
      int w;
      bit hi;
      logic [N-1:0] clr, nz;
      w = pick();
      hi = (w >= 0) && (lvl[w] >= 4);
      clr = '0;
      m_irq = '0;
      case (m_st)
        0: if (m_held && !hi) begin m_st = 4; m_cnt = 0; end
           else if (w >= 0) begin m_st = hi ? 2 : 1; m_act = w; clr[w] = 1'b1; end
        1: if (done) begin m_irq[m_act] = 1'b1; m_st = 0; end
           else if (hi) begin m_st = 3; m_cnt = 0; m_saved = m_act; m_held = 1; end
        2: if (done) begin m_irq[m_act] = 1'b1; m_st = 0; end
        3: if (m_cnt == 1) begin
             if (hi) begin m_st = 2; m_act = w; clr[w] = 1'b1; end else m_st = 0;
           end else m_cnt++;
        4: if (m_cnt == 1) begin m_st = 1; m_act = m_saved; m_held = 0; end
           else m_cnt++;
        default: m_st = 0;
      endcase
      for (int i = 0; i < N; i++) nz[i] = (lvl[i] != 0);
      m_pend = (m_pend & ~clr) | (req & nz);
    end
  end

  always @(negedge clk) if (cmp_en) begin
    check("R7 model busy", busy, (m_st == 1 || m_st == 2));
    if (busy) check("R2 model act", act, m_act);
    check("R4 model save", save, m_st == 3);
    check("R4 model preempt", preempt, (m_st == 3 && m_cnt == 0));
    check("R6 model restore", restore, m_st == 4);
    check("R8 model irq", irq, m_irq);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(int ch);
    req = N'(1) << ch; tick(); req = '0;
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = '0; done = 1'b0;
    for (int i = 0; i < N; i++) lvl[i] = '0;
    tick(2);
    check("R10 reset busy", busy, 0);
    check("R10 reset strobes", {preempt, save, restore}, 0);
    check("R10 reset irq", irq, 0);
    rst_n = 1'b1;
    tick();
    cmp_en = 1;
    check("R10 after reset busy", busy, 0);

    // R1: disabled channel
    pulse_req(2);
    tick(4);
    check("R1 level0 ignored", busy, 0);

    // R2 / R9: tie on level 2 between ch1 and ch3
    lvl[1] = 3'd2; lvl[3] = 3'd2; lvl[5] = 3'd1; lvl[6] = 3'd3;
    req = 8'b0010_1010; tick(); req = '0;
    check("R9 latched not yet running", busy, 0);
    tick();
    check("R9 started", busy, 1);
    check("R2 tie lowest channel", act, 1);

    // R3: low request while low runs
    pulse_req(6);
    tick(3);
    check("R3 low not preempted act", act, 1);
    check("R3 no save", save, 0);
    pulse_done();
    check("R8 irq on ch1", irq, 8'b0000_0010);
    check("R8 busy drops", busy, 0);
    tick();
    check("R8 irq one cycle", irq, 0);
    check("R2 highest level wins", act, 6);

    // R4: high request preempts low ch6
    lvl[7] = 3'd5;
    pulse_req(7);
    check("R4 not yet", save, 0);
    tick();
    check("R4 preempt strobe", preempt, 1);
    check("R4 save cycle 1", save, 1);
    check("R7 idle in save", busy, 0);
    tick();
    check("R4 preempt single", preempt, 0);
    check("R4 save cycle 2", save, 1);
    tick();
    check("R4 save ends", save, 0);
    check("R4 high runs", act, 7);

    // R5: high running, higher request arrives
    lvl[4] = 3'd7;
    pulse_req(4);
    tick(3);
    check("R5 high kept act", act, 7);
    check("R5 no save", save, 0);

    // R6: pending high goes before restore, then restore, then victim ch6
    pulse_done();
    check("R8 irq ch7", irq, 8'b1000_0000);
    tick();
    check("R6 pending high first", act, 4);
    check("R6 no restore yet", restore, 0);
    pulse_done();
    tick();
    check("R6 restore cycle 1", restore, 1);
    check("R7 idle in restore", busy, 0);
    tick();
    check("R6 restore cycle 2", restore, 1);
    tick();
    check("R6 restore ends", restore, 0);
    check("R6 victim resumes", act, 6);
    pulse_done();
    tick();
    check("R2 next low", act, 3);
    pulse_done(); tick();
    pulse_done(); tick(2);
    check("R8 drained", busy, 0);
    done = 1'b1; tick(); done = 1'b0;
    check("R8 done while idle ignored", irq, 0);

    // random phases
    for (int ph = 0; ph < 10; ph++) begin
      req = '0; done = 1'b1;
      tick(60);
      done = 1'b0;
      tick();
      for (int i = 0; i < N; i++) lvl[i] = LW'($urandom % 8);
      for (int c = 0; c < 300; c++) begin
        for (int i = 0; i < N; i++) req[i] = ($urandom % 10) == 0;
        done = ($urandom % 5) == 0;
        tick();
      end
    end
    req = '0; done = 1'b0;
    tick(2);
    summary();
  end

endmodule